// File: doc/BRIEF.md
# I2C Slave Address Matcher with Clock-Stretch Control

This block watches a two-wire bus from the slave side and decides whether the
current transfer is addressed to this device. After a START it samples SDA on
every rising SCL edge and builds the address byte or bytes. It compares them
with a programmed own address in 7-bit or 10-bit form. The all-zeros
general-call byte is also recognised, but only when software enables it.

On a hit the block raises a match or general-call flag and emits a one-cycle
event. The controller uses that event to leave master mode. The block records
the read/write direction and, during each acknowledge slot it owns, pulls SDA
low when the ACK-select input asks for an ACK. Once addressed, it can hold SCL
low after the 8th or the 9th falling SCL edge of every byte. The hold lasts
until a software release pulse arrives.

SDA and SCL are taken as already glitch-free levels and are resynchronised to
the system clock inside the block. Any START or STOP on the bus restarts
address recognition.

Top module: `i2c_amx`

## Requirements
- R1: While reset is asserted and right after it, addr_match_o, gc_match_o, dir_rd_o, hit_o, sda_pull_o and scl_hold_o are all 0.
- R2: With ext_addr_i=0, a first byte whose bits 7:1 (first seven bits on the wire) equal own_addr_i[6:0] sets addr_match_o after the 8th SCL falling edge. The flag stays set until the next START or STOP. hit_o pulses high for exactly one clock when the match is declared.
- R3: dir_rd_o equals the R/W bit of the matched address. That bit is bit 0 of the 7-bit address byte, or of the 10-bit header byte (1 = master reads). dir_rd_o is 0 while no address match is held.
- R4: A first byte of 8'h00 sets gc_match_o and is acknowledged when gc_en_i=1. When gc_en_i=0, the same byte raises no flag and drives no ACK. addr_match_o and gc_match_o are never 1 together.
- R5: During the acknowledge slot of an address or data byte that the block acknowledges, sda_pull_o is 1 when ack_sel_i=0 (ACK) and 0 when ack_sel_i=1 (NACK). The slot runs from the 8th to the 9th falling SCL edge.
- R6: With ext_addr_i=1, a first byte of 5'b11110, own_addr_i[9:8] and R/W is acknowledged without setting addr_match_o. A following byte equal to own_addr_i[7:0] sets addr_match_o and is acknowledged.
- R7: With ext_addr_i=1, a second byte that differs from own_addr_i[7:0] is not acknowledged and sets no flag. A header whose bits 2:1 differ from own_addr_i[9:8] is not acknowledged either.
- R8: A non-matching address drives neither SDA nor SCL. Every later byte is ignored until the next START, including a byte equal to the own address.
- R9: Once addressed with stretch_en_i=1, scl_hold_o rises after the 8th SCL falling edge of each byte when stretch_sel_i=1, and after the 9th when stretch_sel_i=0. It returns to 0 in the clock after release_i is 1.
- R10: With stretch_en_i=0, scl_hold_o stays 0 for either value of stretch_sel_i.
- R11: A START or STOP clears addr_match_o, gc_match_o and dir_rd_o. After a repeated START a new address is matched afresh.
- R12: After a match, each data byte in a write transfer (dir 0) is acknowledged per ack_sel_i. In a read transfer (dir 1) the block leaves SDA released in the acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level (filtered) |
| sda_i | input | 1 | Bus data level (filtered) |
| own_addr_i | input | 10 | Own slave address; bits 6:0 used in 7-bit mode |
| ext_addr_i | input | 1 | 1 selects 10-bit matching, 0 selects 7-bit |
| gc_en_i | input | 1 | 1 lets the block answer the general-call byte |
| ack_sel_i | input | 1 | Acknowledge level: 0 = ACK (pull SDA), 1 = NACK |
| stretch_en_i | input | 1 | 1 allows clock stretching |
| stretch_sel_i | input | 1 | 1 = hold after 8th falling edge, 0 = after 9th |
| release_i | input | 1 | One-cycle pulse that ends an SCL hold |
| addr_match_o | output | 1 | Own address matched in the current transfer |
| gc_match_o | output | 1 | General-call address accepted |
| dir_rd_o | output | 1 | Direction of the matched transfer, 1 = read |
| hit_o | output | 1 | One-cycle event on address or general-call match |
| sda_pull_o | output | 1 | Enable for the SDA pull-low driver |
| scl_hold_o | output | 1 | Enable for the SCL hold-low driver |

## Verification
The bench builds the block with the default of two resynchroniser stages and a
bus phase of eight system clocks. That is long enough that every bus event
reaches the outputs well before the next SCL transition. The bench models
open-drain wires, so the block's SDA pull and SCL hold feed back onto the bus
it samples. This reaches ACK sampling, held clocks and release timing at both
stretch points. It also covers both address widths, the enabled and disabled
general call, header and low-byte mismatches, and repeated START.

// File: rtl/i2c_amx_pkg.sv
package i2c_amx_pkg;

    localparam int ADDR_W  = 10;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(BYTE_W + 2);
    localparam int A7_W    = 7;
    localparam int HDR_W   = 5;

    localparam logic [HDR_W-1:0] HDR10      = 5'b11110;
    localparam logic [CNT_W-1:0] CNT_BYTE   = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ACK    = CNT_W'(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADR1 = 2'd1,
        ST_ADR2 = 2'd2,
        ST_DATA = 2'd3
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              own_ack;
        logic              am;
        logic              gc;
        logic              dir;
        logic              pull;
        logic              hold;
        logic              hit;
    } core_t;

    localparam core_t CORE_RST = '{
        st:      ST_IDLE,
        cnt:     '0,
        sh:      '0,
        own_ack: 1'b0,
        am:      1'b0,
        gc:      1'b0,
        dir:     1'b0,
        pull:    1'b0,
        hold:    1'b0,
        hit:     1'b0
    };

endpackage

// File: rtl/i2c_amx_busmon.sv
module i2c_amx_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_o
);

    logic [SYNC_STAGES-1:0] scl_sync_d, scl_sync_q;
    logic [SYNC_STAGES-1:0] sda_sync_d, sda_sync_q;
    logic scl_prev_d, scl_prev_q;
    logic sda_prev_d, sda_prev_q;
    logic scl_now, sda_now;

    // resynchroniser chain, one flop per stage
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            assign scl_sync_d[g] = scl_i;
            assign sda_sync_d[g] = sda_i;
        end else begin : g_next
            assign scl_sync_d[g] = scl_sync_q[g-1];
            assign sda_sync_d[g] = sda_sync_q[g-1];
        end
    end

    assign scl_now = scl_sync_q[SYNC_STAGES-1];
    assign sda_now = sda_sync_q[SYNC_STAGES-1];

    always_comb begin
        scl_prev_d = scl_now;
        sda_prev_d = sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync_q <= '1;
            sda_sync_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sync_q <= scl_sync_d;
            sda_sync_q <= sda_sync_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_rise_o = scl_now & ~scl_prev_q;
    assign scl_fall_o = ~scl_now & scl_prev_q;
    assign start_o    = scl_now & scl_prev_q & sda_prev_q & ~sda_now;
    assign stop_o     = scl_now & scl_prev_q & ~sda_prev_q & sda_now;
    assign sda_o      = sda_now;

endmodule

// File: rtl/i2c_amx_cmp.sv
module i2c_amx_cmp
    import i2c_amx_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] own_i,
    input  logic              gc_en_i,
    output logic              gc_hit_o,
    output logic              a7_hit_o,
    output logic              hdr_hit_o,
    output logic              lo_hit_o
);

    logic zero_byte;

    always_comb begin
        zero_byte = (byte_i == '0);
        gc_hit_o  = zero_byte & gc_en_i;
        a7_hit_o  = ~zero_byte & (byte_i[BYTE_W-1:1] == own_i[A7_W-1:0]);
        hdr_hit_o = (byte_i[BYTE_W-1:BYTE_W-HDR_W] == HDR10) &&
                    (byte_i[2:1] == own_i[ADDR_W-1:BYTE_W]);
        lo_hit_o  = (byte_i == own_i[BYTE_W-1:0]);
    end

endmodule

// File: rtl/i2c_amx.sv
module i2c_amx
    import i2c_amx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              ext_addr_i,
    input  logic              gc_en_i,
    input  logic              ack_sel_i,
    input  logic              stretch_en_i,
    input  logic              stretch_sel_i,
    input  logic              release_i,
    output logic              addr_match_o,
    output logic              gc_match_o,
    output logic              dir_rd_o,
    output logic              hit_o,
    output logic              sda_pull_o,
    output logic              scl_hold_o
);

    core_t q, d;
    logic  rise, fall, start, stop, sda;
    logic  gc_hit, a7_hit, hdr_hit, lo_hit;

    i2c_amx_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (rise),
        .scl_fall_o (fall),
        .start_o    (start),
        .stop_o     (stop),
        .sda_o      (sda)
    );

    i2c_amx_cmp u_cmp (
        .byte_i    (q.sh),
        .own_i     (own_addr_i),
        .gc_en_i   (gc_en_i),
        .gc_hit_o  (gc_hit),
        .a7_hit_o  (a7_hit),
        .hdr_hit_o (hdr_hit),
        .lo_hit_o  (lo_hit)
    );

    always_comb begin
        d     = q;
        d.hit = 1'b0;
        if (stop) begin
            d = CORE_RST;
        end else if (start) begin
            d    = CORE_RST;
            d.st = ST_ADR1;
        end else begin
            if (q.hold && release_i) begin
                d.hold = 1'b0;
            end
            if (q.st != ST_IDLE) begin
                if (rise) begin
                    if (q.cnt < CNT_BYTE) begin
                        d.sh = {q.sh[BYTE_W-2:0], sda};
                    end
                    d.cnt = q.cnt + CNT_ONE;
                end
                // falling edge closing the eighth bit: decide and open ack slot
                if (fall && (q.cnt == CNT_BYTE)) begin
                    case (q.st)
                        ST_ADR1: begin
                            if (gc_hit) begin
                                d.gc      = 1'b1;
                                d.hit     = 1'b1;
                                d.own_ack = 1'b1;
                                d.st      = ST_DATA;
                            end else if (!ext_addr_i && a7_hit) begin
                                d.am      = 1'b1;
                                d.hit     = 1'b1;
                                d.dir     = q.sh[0];
                                d.own_ack = 1'b1;
                                d.st      = ST_DATA;
                            end else if (ext_addr_i && hdr_hit) begin
                                d.dir     = q.sh[0];
                                d.own_ack = 1'b1;
                                d.st      = ST_ADR2;
                            end else begin
                                d.st      = ST_IDLE;
                            end
                        end
                        ST_ADR2: begin
                            if (lo_hit) begin
                                d.am      = 1'b1;
                                d.hit     = 1'b1;
                                d.own_ack = 1'b1;
                                d.st      = ST_DATA;
                            end else begin
                                d.dir     = 1'b0;
                                d.st      = ST_IDLE;
                            end
                        end
                        ST_DATA: d.own_ack = ~q.dir;
                        default: d.own_ack = 1'b0;
                    endcase
                    d.pull = d.own_ack & ~ack_sel_i;
                    if (stretch_en_i && stretch_sel_i && (d.am || d.gc)) begin
                        d.hold = 1'b1;
                    end
                end
                // falling edge closing the ack slot: release SDA, next byte
                if (fall && (q.cnt == CNT_ACK)) begin
                    d.pull    = 1'b0;
                    d.own_ack = 1'b0;
                    d.cnt     = '0;
                    if (stretch_en_i && !stretch_sel_i && (q.am || q.gc)) begin
                        d.hold = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CORE_RST;
        end else begin
            q <= d;
        end
    end

    assign addr_match_o = q.am;
    assign gc_match_o   = q.gc;
    assign dir_rd_o     = q.dir & q.am;
    assign hit_o        = q.hit;
    assign sda_pull_o   = q.pull;
    assign scl_hold_o   = q.hold;

endmodule

// File: rtl/i2c_amx_chk.sv
module i2c_amx_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_addr_i,
    input logic stretch_en_i,
    input logic release_i,
    input logic addr_match_o,
    input logic gc_match_o,
    input logic dir_rd_o,
    input logic hit_o,
    input logic sda_pull_o,
    input logic scl_hold_o
);

    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o); // R2

    AST_HIT_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (addr_match_o || gc_match_o)); // R2

    AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_match_o && $past(addr_match_o)) |-> $stable(dir_rd_o)); // R3

    AST_DIR_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rd_o |-> addr_match_o); // R3

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_match_o && gc_match_o)); // R4

    AST_PULL_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o && !ext_addr_i) |-> (addr_match_o || gc_match_o)); // R8

    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold_o && release_i) |=> !scl_hold_o); // R9

    AST_HOLD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold_o) |-> $past(stretch_en_i)); // R10

endmodule

bind i2c_amx i2c_amx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_addr_i   (ext_addr_i),
    .stretch_en_i (stretch_en_i),
    .release_i    (release_i),
    .addr_match_o (addr_match_o),
    .gc_match_o   (gc_match_o),
    .dir_rd_o     (dir_rd_o),
    .hit_o        (hit_o),
    .sda_pull_o   (sda_pull_o),
    .scl_hold_o   (scl_hold_o)
);

// File: tb/i2c_amx_tb.sv
`timescale 1ns/1ps
module i2c_amx_tb;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [9:0] own = 10'h02D;
    logic ext = 1'b0, gc_en = 1'b0, ack_sel = 1'b0;
    logic st_en = 1'b0, st_sel = 1'b0, rel = 1'b0;
    logic am, gc, dir, hit, pull, hold;
    logic scl_w, sda_w;

    int total = 0, bad = 0, hits = 0;
    logic last_ack, last_h8, last_h9;

    always #10 clk = ~clk;

    assign scl_w = scl_m & ~hold;
    assign sda_w = sda_m & ~pull;

    i2c_amx u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w),
        .own_addr_i(own), .ext_addr_i(ext), .gc_en_i(gc_en),
        .ack_sel_i(ack_sel), .stretch_en_i(st_en), .stretch_sel_i(st_sel),
        .release_i(rel), .addr_match_o(am), .gc_match_o(gc),
        .dir_rd_o(dir), .hit_o(hit), .sda_pull_o(pull), .scl_hold_o(hold)
    );

    always @(posedge clk) if (rst_n && hit) hits <= hits + 1;

    typedef struct packed {
        logic       ext;
        logic [9:0] own;
        logic       gc_en;
        logic       ack_sel;
        logic [7:0] b1;
        logic [7:0] b2;
        logic       e_am;
        logic       e_gc;
        logic       e_dir;
        logic       e_ack1;
        logic       e_ack2;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 10'h02D, 1'b0, 1'b0, 8'h5A, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 10'h02D, 1'b0, 1'b1, 8'h5B, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 10'h02D, 1'b1, 1'b0, 8'h5C, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 10'h02D, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b0, 10'h02D, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 10'h2C5, 1'b0, 1'b0, 8'hF4, 8'hC5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b1, 10'h2C5, 1'b0, 1'b0, 8'hF4, 8'hC4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b1, 10'h2C5, 1'b0, 1'b0, 8'hF2, 8'hC5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 10'h2C5, 1'b0, 1'b0, 8'hF4, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 10'h2C5, 1'b0, 1'b0, 8'hF5, 8'hC5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        '{1'b1, 10'h2C5, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic pulse_release();
        @(negedge clk); rel = 1'b1;
        @(negedge clk); rel = 1'b0;
        repeat (3) @(negedge clk);
        chk(hold == 1'b0, "R9 hold dropped after release", hold, 0);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq();
            scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq();
        last_ack = ~sda_w;
        last_h8  = hold;
        if (hold) pulse_release();
        scl_m = 1'b1; wq();
        scl_m = 1'b0; wq();
        last_h9  = hold;
        if (hold) pulse_release();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int h0;
        repeat (4) @(negedge clk);
        chk({am, gc, dir, hit, pull, hold} == 6'b0, "R1 outputs in reset", {am, gc, dir, hit, pull, hold}, 0);
        rst_n = 1'b1;
        wq();
        chk({am, gc, dir, hit, pull, hold} == 6'b0, "R1 outputs after reset", {am, gc, dir, hit, pull, hold}, 0);

        // table walk: both widths, general call, mismatches, direction, ack level
        for (int v = 0; v < NV; v++) begin
            ext = VEC[v].ext; own = VEC[v].own; gc_en = VEC[v].gc_en; ack_sel = VEC[v].ack_sel;
            h0 = hits;
            bus_start();
            send_byte(VEC[v].b1);
            chk(last_ack == VEC[v].e_ack1, $sformatf("R5 R4 R6 vec%0d first ack", v), last_ack, VEC[v].e_ack1);
            if (VEC[v].ext && VEC[v].b1 != 8'h00) begin
                chk(am == 1'b0, $sformatf("R6 vec%0d no match after header", v), am, 0);
                send_byte(VEC[v].b2);
                chk(last_ack == VEC[v].e_ack2, $sformatf("R6 R7 vec%0d second ack", v), last_ack, VEC[v].e_ack2);
            end
            chk(am == VEC[v].e_am, $sformatf("R2 R6 R7 R8 vec%0d match", v), am, VEC[v].e_am);
            chk(gc == VEC[v].e_gc, $sformatf("R4 vec%0d gc", v), gc, VEC[v].e_gc);
            chk(dir == VEC[v].e_dir, $sformatf("R3 vec%0d dir", v), dir, VEC[v].e_dir);
            chk(hits - h0 == int'(VEC[v].e_am | VEC[v].e_gc), $sformatf("R2 vec%0d hit pulses", v),
                hits - h0, int'(VEC[v].e_am | VEC[v].e_gc));
            bus_stop();
            chk({am, gc, dir} == 3'b0, $sformatf("R11 vec%0d cleared by stop", v), {am, gc, dir}, 0);
        end

        // R12: write data bytes acked per ack_sel
        ext = 1'b0; own = 10'h02D; gc_en = 1'b0; ack_sel = 1'b0;
        bus_start(); send_byte(8'h5A);
        send_byte(8'h33);
        chk(last_ack == 1'b1, "R12 write data ACK", last_ack, 1);
        ack_sel = 1'b1;
        send_byte(8'hC3);
        chk(last_ack == 1'b0, "R12 R5 write data NACK", last_ack, 0);
        bus_stop();

        // R12: read transfer leaves data ack slot to the master
        ack_sel = 1'b0;
        bus_start(); send_byte(8'h5B);
        send_byte(8'hFF);
        chk(last_ack == 1'b0, "R12 read data no drive", last_ack, 0);
        bus_stop();

        // R9: stretch after 8th falling edge
        st_en = 1'b1; st_sel = 1'b1;
        bus_start(); send_byte(8'h5A);
        chk(last_h8 == 1'b1, "R9 sel1 hold at 8th", last_h8, 1);
        chk(last_h9 == 1'b0, "R9 sel1 no hold at 9th", last_h9, 0);
        send_byte(8'h12);
        chk(last_h8 == 1'b1, "R9 sel1 data hold at 8th", last_h8, 1);
        chk(last_ack == 1'b1, "R9 R5 ack during stretch", last_ack, 1);
        bus_stop();

        // R9: stretch after 9th falling edge
        st_sel = 1'b0;
        bus_start(); send_byte(8'h5A);
        chk(last_h8 == 1'b0, "R9 sel0 no hold at 8th", last_h8, 0);
        chk(last_h9 == 1'b1, "R9 sel0 hold at 9th", last_h9, 1);
        bus_stop();

        // R10: stretching disabled
        st_en = 1'b0; st_sel = 1'b1;
        bus_start(); send_byte(8'h5A);
        chk({last_h8, last_h9} == 2'b00, "R10 no hold sel1", {last_h8, last_h9}, 0);
        st_sel = 1'b0;
        send_byte(8'h44);
        chk({last_h8, last_h9} == 2'b00, "R10 no hold sel0", {last_h8, last_h9}, 0);
        bus_stop();

        // R8: mismatch, then own address without START is ignored
        st_en = 1'b1; st_sel = 1'b1;
        bus_start(); send_byte(8'h5C);
        chk({last_ack, last_h8, last_h9} == 3'b000, "R8 mismatch no drive", {last_ack, last_h8, last_h9}, 0);
        send_byte(8'h5A);
        chk({last_ack, last_h8, am} == 3'b000, "R8 later byte ignored", {last_ack, last_h8, am}, 0);
        bus_stop();

        // R11: repeated START clears and rematches
        st_en = 1'b0;
        bus_start(); send_byte(8'h5A);
        chk(am == 1'b1, "R11 first match", am, 1);
        bus_start();
        chk(am == 1'b0, "R11 cleared by repeated start", am, 0);
        send_byte(8'h5B);
        chk({am, dir} == 2'b11, "R11 R3 rematch read", {am, dir}, 3);
        bus_stop();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule